// File: doc/BRIEF.md
# Two-Phase Palette Write Staging Controller

This block is a register-mapped palette controller. Every palette colour holds a 9-bit colour and a priority flag. Software loads a colour by writing one data register twice. The first byte goes into a staging byte and the palette is not touched. The second byte supplies the ninth colour bit and the priority flag, and that write commits the full entry to palette storage. After the commit, the palette index moves to the next entry.

A shared register address does two unrelated jobs, depending on the direction of access. A write to it sets a one-bit keymap address MSB, which leaves the block on its own pin. A read from it returns the staged first byte of the most recent colour write. The normal palette readback shows only committed entries, so a half-written colour never appears there. The staged byte stays readable after the commit.

Register addresses on both the write port and the read port:

- 0: palette index.
- 1: palette data, and on read the 8 upper colour bits of the entry at the index.
- 2: shared keymap/staging register.
- 3: read-only view of the second byte of the entry at the index.

Top module: `pal_stage_ctrl`

## Requirements
- R1: A write to address 2 sets `keymap_msb` to bit 0 of the write data one cycle later. Bits 7:1 of that write have no effect on any readable state.
- R2: A read of address 2 returns the 8-bit staged byte, never the keymap MSB.
- R3: The first write to address 1 after reset, after an index write, or after a commit loads the whole data byte into the staging byte. The new value is readable at address 2 on the next cycle.
- R4: A first-phase write to address 1 leaves the palette entry unchanged. Reads at address 1 and address 3 keep returning the previously committed entry.
- R5: The second write to address 1 commits an entry at the current index. Its priority comes from data bit 7, colour bits 8:1 come from the staged byte, and colour bit 0 comes from data bit 0. Data bits 6:1 are ignored. A read at address 1 returns colour bits 8:1. A read at address 3 returns the priority in bit 7 and colour bit 0 in bit 0, with bits 6:1 reading as zero.
- R6: After a commit, address 2 still returns the first byte of that colour.
- R7: A commit increments the index by one, wrapping from 255 to 0. It also returns the write phase to first-byte.
- R8: A write to address 0 loads the index from the data byte and returns the write phase to first-byte. A pending first byte is abandoned: it stays staged but is not committed.
- R9: Reset clears the keymap MSB, the staging byte, the write phase, the index and every palette entry to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address of the write |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Register address of the combinational read |
| rd_data | output | 8 | Read data for `rd_addr` |
| keymap_msb | output | 1 | Keymap address MSB |

## Verification
The bench targets the half-written state. A design that commits on the first byte would change the address 1 readback one write too early. A design that clears the staging byte on commit would read back zero at address 2. The bench also writes the index between the two halves of a colour. A design that does not reset the phase would commit the second half of that sequence as a stray entry. Commits at index 255 expose a wrong wrap, and second bytes full of ignored bits expose a design that packs them into the entry. A keymap write of 0xFE shows whether the reserved bits leak or clobber the staged byte.

// File: rtl/pal_stage_pkg.sv
package pal_stage_pkg;
    localparam int BYTE_W   = 8;
    localparam int COLOUR_W = 9;

    typedef enum logic [1:0] {
        REG_INDEX  = 2'd0,
        REG_DATA   = 2'd1,
        REG_SHARED = 2'd2,
        REG_HIGH   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic                prio;
        logic [COLOUR_W-1:0] colour;
    } pal_entry_t;
endpackage

// File: rtl/pal_stage_latch.sv
module pal_stage_latch
    import pal_stage_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic              index_wr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] stage_q,
    output logic              phase_q,
    output logic              commit_en,
    output pal_entry_t        commit_entry
);
    typedef struct packed {
        logic [BYTE_W-1:0] stage;
        logic              phase;
    } stage_st_t;

    stage_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        commit_en    = 1'b0;
        commit_entry = '0;
        if (index_wr) begin
            st_d.phase = 1'b0;
        end else if (data_wr) begin
            if (!st_q.phase) begin
                st_d.stage = wr_data;
                st_d.phase = 1'b1;
            end else begin
                commit_en           = 1'b1;
                commit_entry.prio   = wr_data[7];
                commit_entry.colour = {st_q.stage, wr_data[0]};
                st_d.phase          = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stage_q = st_q.stage;
    assign phase_q = st_q.phase;
endmodule

// File: rtl/pal_index_reg.sv
module pal_index_reg
    import pal_stage_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              index_wr,
    input  logic              commit_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [IDX_W-1:0]  idx_q
);
    logic [IDX_W-1:0] idx_d;

    always_comb begin
        idx_d = idx_q;
        if (index_wr)       idx_d = wr_data[IDX_W-1:0];
        else if (commit_en) idx_d = idx_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end
endmodule

// File: rtl/pal_store.sv
module pal_store
    import pal_stage_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  pal_entry_t       wentry,
    input  logic [IDX_W-1:0] raddr,
    output pal_entry_t       rentry
);
    localparam int ENTRIES = 1 << IDX_W;

    pal_entry_t mem_d [ENTRIES];
    pal_entry_t mem_q [ENTRIES];

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) mem_d[i] = mem_q[i];
        if (we) mem_d[waddr] = wentry;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    assign rentry = mem_q[raddr];
endmodule

// File: rtl/pal_stage_ctrl.sv
module pal_stage_ctrl
    import pal_stage_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic [1:0]  rd_addr,
    output logic [7:0]  rd_data,
    output logic        keymap_msb
);
    logic              index_wr, data_wr, shared_wr;
    logic [BYTE_W-1:0] stage_q;
    logic              phase_q;
    logic              commit_en;
    pal_entry_t        commit_entry;
    pal_entry_t        cur_entry;
    logic [IDX_W-1:0]  idx_q;
    logic [BYTE_W-1:0] idx_byte;
    logic              km_d, km_q;

    assign index_wr  = wr_en && (reg_addr_e'(wr_addr) == REG_INDEX);
    assign data_wr   = wr_en && (reg_addr_e'(wr_addr) == REG_DATA);
    assign shared_wr = wr_en && (reg_addr_e'(wr_addr) == REG_SHARED);

    pal_stage_latch u_stage (
        .clk          (clk),
        .rst_n        (rst_n),
        .data_wr      (data_wr),
        .index_wr     (index_wr),
        .wr_data      (wr_data),
        .stage_q      (stage_q),
        .phase_q      (phase_q),
        .commit_en    (commit_en),
        .commit_entry (commit_entry)
    );

    pal_index_reg #(.IDX_W(IDX_W)) u_index (
        .clk       (clk),
        .rst_n     (rst_n),
        .index_wr  (index_wr),
        .commit_en (commit_en),
        .wr_data   (wr_data),
        .idx_q     (idx_q)
    );

    pal_store #(.IDX_W(IDX_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (commit_en),
        .waddr  (idx_q),
        .wentry (commit_entry),
        .raddr  (idx_q),
        .rentry (cur_entry)
    );

    generate
        if (IDX_W < BYTE_W) begin : g_idx_pad
            assign idx_byte = {{(BYTE_W-IDX_W){1'b0}}, idx_q};
        end else begin : g_idx_full
            assign idx_byte = idx_q[BYTE_W-1:0];
        end
    endgenerate

    always_comb begin
        km_d = km_q;
        if (shared_wr) km_d = wr_data[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) km_q <= 1'b0;
        else        km_q <= km_d;
    end

    assign keymap_msb = km_q;

    always_comb begin
        unique case (reg_addr_e'(rd_addr))
            REG_INDEX:  rd_data = idx_byte;
            REG_DATA:   rd_data = cur_entry.colour[COLOUR_W-1:1];
            REG_SHARED: rd_data = stage_q;
            REG_HIGH:   rd_data = {cur_entry.prio, 6'b0, cur_entry.colour[0]};
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pal_stage_chk.sv
module pal_stage_chk
    import pal_stage_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [7:0]        wr_data,
    input logic              keymap_msb,
    input logic [BYTE_W-1:0] stage_q,
    input logic              phase_q,
    input logic [IDX_W-1:0]  idx_q,
    input pal_entry_t        cur_entry
);
    logic first_wr, second_wr, idx_wr, sh_wr;
    assign first_wr  = wr_en && wr_addr == 2'd1 && !phase_q;
    assign second_wr = wr_en && wr_addr == 2'd1 && phase_q;
    assign idx_wr    = wr_en && wr_addr == 2'd0;
    assign sh_wr     = wr_en && wr_addr == 2'd2;

    AST_KEYMAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        sh_wr |=> keymap_msb == $past(wr_data[0])); // R1
    AST_STAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        first_wr |=> stage_q == $past(wr_data) && phase_q); // R3
    AST_NO_EARLY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        first_wr |=> $stable(cur_entry) && $stable(idx_q)); // R4
    AST_STAGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        second_wr |=> $stable(stage_q)); // R6
    AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        second_wr |=> idx_q == IDX_W'($past(idx_q) + 1'b1) && !phase_q); // R7
    AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> !phase_q && $stable(stage_q)); // R8
endmodule

bind pal_stage_ctrl pal_stage_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .keymap_msb (keymap_msb),
    .stage_q    (stage_q),
    .phase_q    (phase_q),
    .idx_q      (idx_q),
    .cur_entry  (cur_entry)
);

// File: tb/tb_pal_stage_ctrl.sv
module tb_pal_stage_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       keymap_msb;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int m_pal [256];
    int m_stage, m_phase, m_idx, m_km;

    always #(CLK_PERIOD/2) clk = ~clk;

    pal_stage_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .keymap_msb(keymap_msb)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) m_pal[i] = 0;
            m_stage = 0; m_phase = 0; m_idx = 0; m_km = 0;
        end else if (wr_en) begin
            case (wr_addr)
                2'd0: begin m_idx = wr_data; m_phase = 0; end
                2'd1: begin
                    if (m_phase == 0) begin
                        m_stage = wr_data; m_phase = 1;
                    end else begin
                        m_pal[m_idx] = (wr_data[7] << 9) | (m_stage << 1) | wr_data[0];
                        m_idx = (m_idx + 1) % 256;
                        m_phase = 0;
                    end
                end
                2'd2: m_km = wr_data[0];
                default: ;
            endcase
        end
    end

    function automatic int model_read(input int a);
        int e;
        e = m_pal[m_idx];
        case (a)
            0: return m_idx;
            1: return (e >> 1) & 255;
            2: return m_stage;
            default: return (((e >> 9) & 1) << 7) | (e & 1);
        endcase
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // compares every read address and the keymap pin against the model
    task automatic cmp_all(input string tag);
        for (int a = 0; a < 4; a++) begin
            rd_addr = a[1:0];
            #1;
            case (a)
                0: check({tag, " R7 index"}, rd_data, model_read(a));
                1: check({tag, " R4 R5 colour-high"}, rd_data, model_read(a));
                2: check({tag, " R2 R3 R6 staged"}, rd_data, model_read(a));
                default: check({tag, " R5 second-byte"}, rd_data, model_read(a));
            endcase
        end
        check({tag, " R1 keymap"}, keymap_msb, m_km);
    endtask

    task automatic wr(input int a, input int d, input string tag);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[7:0];
        @(negedge clk);
        wr_en = 1'b0;
        cmp_all(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_all("R9 reset");
        for (int i = 0; i < 256; i += 37) begin
            wr(0, i, "R9 scan index");
        end
        wr(0, 0, "R8 index home");
        // keymap: reserved bits ignored, staged byte untouched
        wr(2, 8'hFF, "R1 keymap set");
        wr(2, 8'hFE, "R1 keymap clear reserved");
        // half-written colour
        wr(1, 8'hA5, "R3 R4 first byte");
        wr(1, 8'h81, "R5 R6 R7 commit");
        wr(0, 0, "R5 back to entry 0");
        // ignored bits in second byte
        wr(1, 8'h3C, "R3 first byte");
        wr(1, 8'h7E, "R5 ignored bits");
        // index write mid-colour abandons the first byte
        wr(0, 10, "R8 index");
        wr(1, 8'h11, "R3 first byte");
        wr(0, 20, "R8 abandon");
        wr(1, 8'h22, "R8 restart first");
        wr(1, 8'h80, "R5 commit after restart");
        wr(2, 8'h01, "R2 shared read staged");
        // wrap at 255
        wr(0, 255, "R7 index top");
        wr(1, 8'hC3, "R3 first");
        wr(1, 8'h01, "R7 wrap");
        wr(0, 255, "R7 read top");
        // random traffic
        for (int n = 0; n < 400; n++) begin
            wr($urandom_range(0, 3), $urandom_range(0, 255), "random");
        end
        finish_run();
    end
endmodule